// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a small load-store RISC core. In a single combinational pass it combines a first operand with a second operand that the shifter has already prepared. The 4-bit operation code selects one of sixteen functions: four bitwise functions, two moves, six add and subtract forms, and four compares. The block returns the result and a write-back enable. It also returns the next value of the four condition flags: negative, zero, carry and overflow.

A flag register inside the block holds the flags from one operation to the next. Its carry bit feeds the carry-using add and subtract forms. How the flags change depends on the class of the operation. Compares always update the flags and never write a result. Every other operation updates the flags only when the caller asks for it. Arithmetic operations recompute all four flags. Bitwise and move operations keep overflow. They take carry from the shifter when the shifter actually moved the operand, and keep carry otherwise.

The flag vector is packed as {N, Z, C, V}: bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. One operation is presented on every clock cycle.

Top module: `dp_alu_core`

## Requirements
- R1: Bitwise codes give these results. 0000 gives A AND B. 0001 gives A XOR B. 1100 gives A OR B. 1110 gives A AND NOT B.
- R2: Code 1101 returns B, and code 1111 returns NOT B.
- R3: The add and subtract codes give these results, where C is the registered carry flag. 0100 gives A+B. 0101 gives A+B+C. 0010 gives A-B. 0110 gives A-B+C-1. 0011 gives B-A. 0111 gives B-A+C-1. All results are taken modulo 2^W.
- R4: Compare codes 1000 (A AND B), 1001 (A XOR B), 1010 (A-B) and 1011 (A+B) hold `wr_en` low. They load the flags on every clock edge, whatever the value of `set_flags`.
- R5: Every non-compare code drives `wr_en` high. When `set_flags` is low, the flag register keeps its value across the edge, and `flags_next` equals `flags_q`.
- R6: On an update, add and subtract codes set C and V as follows. For add forms, C is the carry out. For subtract forms, C is high when no borrow occurs. V is high when the result as a signed number overflows.
- R7: On any update, N takes result bit W-1, and Z is high exactly when every result bit is zero.
- R8: On an update, bitwise, move and test codes keep V. They load C from `shift_carry` when `shift_applied` is high, and keep C when it is low.
- R9: While `rst_n` is low, the flag register clears to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| opcode | input | 4 | Operation select |
| op_a | input | W | First operand |
| op_b | input | W | Second operand, already shifted |
| set_flags | input | 1 | Flag update request for non-compare codes |
| shift_applied | input | 1 | High when the shifter moved operand B |
| shift_carry | input | 1 | Last bit shifted out by the shifter |
| result | output | W | Operation result; meaningless when wr_en is low |
| wr_en | output | 1 | Result write-back enable |
| flags_next | output | 4 | Flags to be loaded at the next edge, {N,Z,C,V} |
| flags_q | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
The flag register is the only state in the block. A wrong value there shows up on `flags_q` right after the clock edge that loads it. In the same cycle, a wrong carry also changes the result of any carry-using add or subtract. It also reaches `flags_next` on every operation that keeps C, such as a bitwise operation with no shift. A wrong hold or update decision is visible one edge later, as `flags_q` moving when it should stay, or staying when it should move. The sweep steps every code through operand pairs at the sign and carry boundaries, with every combination of update request and shift status. The carry state feeds each following operation, so a fault in one step also changes the steps that come after it.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_EOR = 4'b0001,
        OP_SUB = 4'b0010,
        OP_RSB = 4'b0011,
        OP_ADD = 4'b0100,
        OP_ADC = 4'b0101,
        OP_SBC = 4'b0110,
        OP_RSC = 4'b0111,
        OP_TST = 4'b1000,
        OP_TEQ = 4'b1001,
        OP_CMP = 4'b1010,
        OP_CMN = 4'b1011,
        OP_ORR = 4'b1100,
        OP_MOV = 4'b1101,
        OP_BIC = 4'b1110,
        OP_MVN = 4'b1111
    } alu_op_e;

    typedef enum logic {
        FCLS_LOGIC = 1'b0,
        FCLS_ARITH = 1'b1
    } flag_cls_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    function automatic flag_cls_e op_class(alu_op_e op);
        unique case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: return FCLS_ARITH;
            default:                        return FCLS_LOGIC;
        endcase
    endfunction

    function automatic logic op_is_compare(alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] x, y;
    logic         c0;
    logic [W:0]   wide;

    // Subtraction is rewritten as x + ~y + c0, so C reads as NOT-borrow.
    always_comb begin
        unique case (op)
            OP_ADD, OP_CMN: begin x = a; y = b;  c0 = 1'b0; end
            OP_ADC:         begin x = a; y = b;  c0 = cin;  end
            OP_SUB, OP_CMP: begin x = a; y = ~b; c0 = 1'b1; end
            OP_SBC:         begin x = a; y = ~b; c0 = cin;  end
            OP_RSB:         begin x = b; y = ~a; c0 = 1'b1; end
            OP_RSC:         begin x = b; y = ~a; c0 = cin;  end
            default:        begin x = a; y = b;  c0 = 1'b0; end
        endcase
    end

    assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c0};
    assign sum  = wide[MSB:0];
    assign cout = wide[W];
    assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_BIC:         res = a & ~b;
            OP_MOV:         res = b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           update,
    input  flag_cls_e      cls,
    input  logic [W-1:0]   res,
    input  logic           arith_c,
    input  logic           arith_v,
    input  logic           shift_applied,
    input  logic           shift_carry,
    output logic [3:0]     nzcv_next,
    output logic [3:0]     nzcv_q
);
    localparam int MSB = W - 1;

    always_comb begin
        nzcv_next = nzcv_q;
        if (update) begin
            nzcv_next[FLAG_N] = res[MSB];
            nzcv_next[FLAG_Z] = (res == '0);
            if (cls == FCLS_ARITH) begin
                nzcv_next[FLAG_C] = arith_c;
                nzcv_next[FLAG_V] = arith_v;
            end else if (shift_applied) begin
                nzcv_next[FLAG_C] = shift_carry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nzcv_q <= 4'b0000;
        else        nzcv_q <= nzcv_next;
    end

    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(nzcv_q));

    assert_nz_from_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (nzcv_q[FLAG_N] == $past(res[MSB])) && (nzcv_q[FLAG_Z] == ($past(res) == '0)));

    assert_logic_keeps_v_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (update && cls == FCLS_LOGIC) |=> $stable(nzcv_q[FLAG_V]));

    assert_logic_shift_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (update && cls == FCLS_LOGIC && shift_applied) |=> nzcv_q[FLAG_C] == $past(shift_carry));

    assert_logic_keep_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (update && cls == FCLS_LOGIC && !shift_applied) |=> $stable(nzcv_q[FLAG_C]));

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     opcode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           set_flags,
    input  logic           shift_applied,
    input  logic           shift_carry,
    output logic [W-1:0]   result,
    output logic           wr_en,
    output logic [3:0]     flags_next,
    output logic [3:0]     flags_q
);
    alu_op_e      op;
    flag_cls_e    cls;
    logic         is_cmp;
    logic [W-1:0] arith_sum, logic_res;
    logic         arith_c, arith_v;

    assign op     = alu_op_e'(opcode);
    assign cls    = op_class(op);
    assign is_cmp = op_is_compare(op);

    dp_alu_addsub #(.W(W)) u_addsub (
        .op   (op),
        .a    (op_a),
        .b    (op_b),
        .cin  (flags_q[FLAG_C]),
        .sum  (arith_sum),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (logic_res)
    );

    assign result = (cls == FCLS_ARITH) ? arith_sum : logic_res;
    assign wr_en  = !is_cmp;

    dp_alu_flags #(.W(W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .update        (is_cmp || set_flags),
        .cls           (cls),
        .res           (result),
        .arith_c       (arith_c),
        .arith_v       (arith_v),
        .shift_applied (shift_applied),
        .shift_carry   (shift_carry),
        .nzcv_next     (flags_next),
        .nzcv_q        (flags_q)
    );

    assert_compare_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |-> !wr_en);

    assert_compare_loads_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |=> flags_q == $past(flags_next));

    assert_plain_op_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] != 2'b10 && !set_flags) |=> flags_q == $past(flags_q));

    assert_plain_op_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] != 2'b10) |-> wr_en);

endmodule

// File: tb/dp_alu_core_tb.sv
module dp_alu_core_tb;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   opcode = 4'd0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         set_flags = 1'b0;
    logic         shift_applied = 1'b0;
    logic         shift_carry = 1'b0;
    logic [W-1:0] result;
    logic         wr_en;
    logic [3:0]   flags_next;
    logic [3:0]   flags_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [3:0] mflags = 4'b0000;

    always #5 clk = ~clk;

    dp_alu_core #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .set_flags(set_flags), .shift_applied(shift_applied), .shift_carry(shift_carry),
        .result(result), .wr_en(wr_en), .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0h a %0h b %0h)",
                     req, what, act, exp, opcode, op_a, op_b);
        end
    endtask

    function automatic int pick(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return HALF - 1;
            3: return HALF;
            4: return MASK;
            5: return MASK - 1;
            default: return (i * 53 + 11) & MASK;
        endcase
    endfunction

    task automatic run_op(int op, int ua, int ub, bit sf, bit sa, bit sc);
        int  c   = mflags[1];
        int  sxa = (ua >= HALF) ? ua - 2 * HALF : ua;
        int  sxb = (ub >= HALF) ? ub - 2 * HALF : ub;
        int  u = 0, s = 0, r = 0;
        bit  arith = 1, addlike = 0, cmp, upd, ec, ev;
        logic [3:0] nx;
        string rq;
        case (op)
            4, 11: begin u = ua + ub;         s = sxa + sxb;         addlike = 1; end
            5:     begin u = ua + ub + c;     s = sxa + sxb + c;     addlike = 1; end
            2, 10: begin u = ua - ub;         s = sxa - sxb;         end
            6:     begin u = ua - ub + c - 1; s = sxa - sxb + c - 1; end
            3:     begin u = ub - ua;         s = sxb - sxa;         end
            7:     begin u = ub - ua + c - 1; s = sxb - sxa + c - 1; end
            default: arith = 0;
        endcase
        if (arith) begin
            r  = u & MASK;
            ec = addlike ? (u > MASK) : (u >= 0);
            ev = (s > HALF - 1) || (s < -HALF);
        end else begin
            case (op)
                0, 8:  r = ua & ub;
                1, 9:  r = ua ^ ub;
                12:    r = ua | ub;
                13:    r = ub;
                14:    r = ua & (~ub & MASK);
                default: r = ~ub & MASK;
            endcase
            ec = 0; ev = 0;
        end
        cmp = (op >= 8) && (op <= 11);
        upd = cmp || sf;
        nx  = mflags;
        if (upd) begin
            nx[3] = (r >> (W - 1)) & 1;
            nx[2] = (r == 0);
            if (arith) begin nx[1] = ec; nx[0] = ev; end
            else if (sa) nx[1] = sc;
        end

        @(negedge clk);
        opcode = op[3:0]; op_a = ua[W-1:0]; op_b = ub[W-1:0];
        set_flags = sf; shift_applied = sa; shift_carry = sc;
        #1;
        if (!cmp) begin
            if (arith)                    rq = "R3";
            else if (op == 13 || op == 15) rq = "R2";
            else                          rq = "R1";
            check(rq, result, r, "result");
        end
        check(cmp ? "R4" : "R5", wr_en, !cmp, "wr_en");
        if (!upd)       rq = "R5";
        else if (arith) rq = "R6/R7";
        else            rq = "R8/R7";
        check(rq, flags_next, nx, "flags_next");
        @(posedge clk);
        #1;
        check(cmp ? "R4" : rq, flags_q, nx, "flags_q");
        mflags = nx;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", flags_q, 0, "reset flags");
        check("R9", flags_next, 0, "reset flags_next");
        @(negedge clk);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    for (int k = 0; k < 4; k++)
                        run_op(op, pick(i), pick(j), k[0], k[1], ((i ^ j ^ k) & 1) == 1);
        // ADC chain across the carry boundary: MASK+1 sets C, then 0+0+C = 1
        run_op(4, MASK, 1, 1, 0, 0);
        run_op(5, 0, 0, 1, 0, 0);
        // SBC with carry clear borrows one extra
        run_op(11, 0, 0, 0, 0, 0);
        run_op(6, 5, 5, 1, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule